// File: doc/BRIEF.md
# Prioritized Interrupt Presentation Unit

This block holds the interrupt presentation state of a single processor: the priority the processor currently runs at, the priority of its inter-processor request, the source number and priority of the one interrupt it is currently offered, and a flag that records a delivery that has been lost. Lower numeric priority values are more favored. An external source side offers interrupts through a delivery request. The processor side reads and acknowledges the pending interrupt, changes its own running priority, posts inter-processor requests and signals end of service. The block drives a level interrupt line toward the processor.

A delivery that beats the interrupt already held displaces it, and the displaced source number is reported on a reject port so the source side can try it again. An inter-processor request posted with a favored enough priority displaces the held interrupt in the same way. A delivery that is refused is not lost. The unit remembers it with a flag, and when the processor later makes its running priority or its request priority less favored, the flag turns into a one-cycle resend request. End-of-service words lower the running priority and are then forwarded to the source side, unless they name the reserved inter-processor source number.

The unit executes one operation per cycle. Every response and event output is registered and appears in the cycle after the request is sampled. The interrupt line follows the stored state directly.

Top module: `irq_presenter`

## Requirements
- R1: After reset the running priority is 0x00, the request priority is 0xFF, the pending priority is 0xFF, no source is pending (source number 0) and the resend flag is clear. All event outputs are low and an acknowledge read returns 0x00000000.
- R2: `irq_out` is high exactly when the pending source number is nonzero and the pending priority is numerically below the running priority. It is low when the two priorities are equal.
- R3: A delivery of priority p is accepted only when the running priority, the request priority and the pending priority are all numerically greater than p. In the cycle after it is executed, `dlv_done` pulses, with `dlv_ok` high for accept and low for refusal. On accept the offered source and p become the pending pair.
- R4: An accepted delivery reports the previously pending source on `rej_valid`/`rej_src`, unless that number is 0 or the reserved inter-processor number 2.
- R5: A refused delivery sets the resend flag. The flag has no visible effect until it is consumed.
- R6: An acknowledge returns on `acc_word` the running priority in bits 31:24 and the pending source in bits 23:0. If the source was nonzero, the running priority takes the pending priority, the pending priority becomes 0xFF and the source becomes 0. Otherwise nothing changes.
- R7: Writing a request priority m stores it. If m is below the running priority and no greater than the pending priority, the held source is rejected as in R4, the pending source becomes 2 and the pending priority becomes m.
- R8: Writing a request priority numerically larger than the stored one clears the resend flag and pulses `resend_pulse` if the flag was set.
- R9: Writing a running priority c numerically larger than the current one stores c. If the request priority is below c and no greater than the pending priority, source 2 becomes pending at the request priority. A set resend flag is consumed into `resend_pulse`. No reject is reported.
- R10: Writing a running priority c numerically smaller than the current one stores c. If c is no greater than the pending priority, the held source is rejected as in R4 and the pending pair becomes (0, 0xFF). Writing the current value changes nothing.
- R11: An end-of-service word applies the R9 rules using bits 31:24 as the new running priority, whatever its relation to the current one. In the next cycle `seoi_valid` pulses with bits 23:0 on `seoi_src`, unless those bits equal 2.
- R12: Simultaneous requests are ranked end-of-service, then running-priority write, then acknowledge, then request-priority write, then delivery. Only the winner executes. The others have no effect and give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlv_req | input | 1 | Delivery offered this cycle |
| dlv_src | input | 24 | Offered source number |
| dlv_prio | input | 8 | Offered priority |
| dlv_done | output | 1 | Delivery executed (one cycle pulse) |
| dlv_ok | output | 1 | Executed delivery was accepted |
| acc_req | input | 1 | Acknowledge/read request |
| acc_done | output | 1 | Acknowledge executed, `acc_word` valid |
| acc_word | output | 32 | Running priority and pending source at acknowledge |
| mfrr_req | input | 1 | Request-priority write |
| mfrr_val | input | 8 | New request priority |
| cppr_req | input | 1 | Running-priority write |
| cppr_val | input | 8 | New running priority |
| eoi_req | input | 1 | End-of-service write |
| eoi_word | input | 32 | Priority in 31:24, source in 23:0 |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | A displaced source is reported |
| rej_src | output | 24 | Displaced source number |
| resend_pulse | output | 1 | Lost deliveries should be offered again |
| seoi_valid | output | 1 | End of service forwarded to the source side |
| seoi_src | output | 24 | Source number that finished service |

## Verification
The operations that can collide are an end-of-service or priority write from the processor and a delivery from the source side, and likewise an acknowledge racing a request-priority write. The bench raises all five request lines in the same cycle, then acknowledge, request-priority and delivery together, then request-priority and delivery together. It judges the result at the ports: only the winner's response appears, and the later acknowledge word and interrupt line show that the losers left the state untouched. A reference model updated in rank order predicts every cycle's outputs.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    localparam int PRI_W  = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRI_W + SRC_W;
    localparam int N_OPS  = 5;

    typedef logic [PRI_W-1:0] pri_t;
    typedef logic [SRC_W-1:0] src_t;

    localparam pri_t PRI_LEAST = '1;
    localparam pri_t PRI_MOST  = '0;
    localparam src_t SRC_NONE  = '0;
    localparam src_t SRC_IPI   = SRC_W'(2);

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EOI,
        OP_CPPR,
        OP_ACCEPT,
        OP_MFRR,
        OP_DELIVER
    } op_e;

    typedef struct packed {
        pri_t run_pri;
        pri_t req_pri;
        src_t pend_src;
        pri_t pend_pri;
        logic lost;
    } pstate_t;

    typedef struct packed {
        logic              dlv_done;
        logic              dlv_ok;
        logic              acc_done;
        logic [WORD_W-1:0] acc_word;
        logic              rej_v;
        src_t              rej_src;
        logic              resend_p;
        logic              seoi_v;
        src_t              seoi_src;
    } pevent_t;

    localparam pstate_t RESET_STATE = '{
        run_pri:  PRI_MOST,
        req_pri:  PRI_LEAST,
        pend_src: SRC_NONE,
        pend_pri: PRI_LEAST,
        lost:     1'b0
    };

    // the inter-processor request takes over the pending slot
    function automatic logic ipi_takes(pri_t req, pri_t run, pri_t pend);
        return (req < run) && (req <= pend);
    endfunction

    // a displaced number is reported only for real sources
    function automatic logic reportable(src_t s);
        return (s != SRC_NONE) && (s != SRC_IPI);
    endfunction

    function automatic logic line_level(pstate_t s);
        return (s.pend_src != SRC_NONE) && (s.pend_pri < s.run_pri);
    endfunction

endpackage

// File: rtl/ipu_arbiter.sv
module ipu_arbiter
    import ipu_pkg::*;
(
    input  logic eoi_req,
    input  logic cppr_req,
    input  logic acc_req,
    input  logic mfrr_req,
    input  logic dlv_req,
    output op_e  op
);

    localparam op_e RANK [N_OPS] = '{OP_EOI, OP_CPPR, OP_ACCEPT, OP_MFRR, OP_DELIVER};

    logic [N_OPS-1:0] req;
    assign req = {dlv_req, mfrr_req, acc_req, cppr_req, eoi_req};

    // highest rank (lowest index) written last, so it wins
    always_comb begin
        op = OP_NONE;
        for (int i = N_OPS - 1; i >= 0; i--) begin
            if (req[i]) begin
                op = RANK[i];
            end
        end
    end

endmodule

// File: rtl/ipu_delivery.sv
module ipu_delivery
    import ipu_pkg::*;
(
    input  pstate_t cur,
    input  src_t    src,
    input  pri_t    pri,
    output logic    ok,
    output pstate_t nxt,
    output logic    rej_v,
    output src_t    rej_src
);

    always_comb begin
        nxt     = cur;
        ok      = (cur.run_pri > pri) && (cur.req_pri > pri) && (cur.pend_pri > pri);
        rej_v   = 1'b0;
        rej_src = SRC_NONE;
        if (ok) begin
            rej_v        = reportable(cur.pend_src);
            rej_src      = rej_v ? cur.pend_src : SRC_NONE;
            nxt.pend_src = src;
            nxt.pend_pri = pri;
        end else begin
            nxt.lost = 1'b1;
        end
    end

endmodule

// File: rtl/ipu_control.sv
module ipu_control
    import ipu_pkg::*;
(
    input  op_e               op,
    input  pstate_t           cur,
    input  pri_t              mfrr_val,
    input  pri_t              cppr_val,
    input  logic [WORD_W-1:0] eoi_word,
    output pstate_t           nxt,
    output logic              acc_done,
    output logic [WORD_W-1:0] acc_word,
    output logic              rej_v,
    output src_t              rej_src,
    output logic              resend_p,
    output logic              seoi_v,
    output src_t              seoi_src
);

    pri_t eoi_pri;
    src_t eoi_src;
    pri_t lower_to;
    logic lowering;

    assign eoi_pri  = eoi_word[WORD_W-1 -: PRI_W];
    assign eoi_src  = eoi_word[SRC_W-1:0];
    assign lower_to = (op == OP_EOI) ? eoi_pri : cppr_val;
    assign lowering = (op == OP_EOI) || ((op == OP_CPPR) && (cppr_val > cur.run_pri));

    always_comb begin
        nxt      = cur;
        acc_done = 1'b0;
        acc_word = '0;
        rej_v    = 1'b0;
        rej_src  = SRC_NONE;
        resend_p = 1'b0;
        seoi_v   = 1'b0;
        seoi_src = SRC_NONE;
        case (op)
            OP_EOI, OP_CPPR: begin
                if (lowering) begin
                    nxt.run_pri = lower_to;
                    if (ipi_takes(cur.req_pri, lower_to, cur.pend_pri)) begin
                        nxt.pend_src = SRC_IPI;
                        nxt.pend_pri = cur.req_pri;
                    end
                    resend_p = cur.lost;
                    nxt.lost = 1'b0;
                end else if (cppr_val < cur.run_pri) begin
                    nxt.run_pri = cppr_val;
                    if (cppr_val <= cur.pend_pri) begin
                        rej_v        = reportable(cur.pend_src);
                        rej_src      = rej_v ? cur.pend_src : SRC_NONE;
                        nxt.pend_src = SRC_NONE;
                        nxt.pend_pri = PRI_LEAST;
                    end
                end
                if ((op == OP_EOI) && (eoi_src != SRC_IPI)) begin
                    seoi_v   = 1'b1;
                    seoi_src = eoi_src;
                end
            end
            OP_ACCEPT: begin
                acc_done = 1'b1;
                acc_word = {cur.run_pri, cur.pend_src};
                if (cur.pend_src != SRC_NONE) begin
                    nxt.run_pri  = cur.pend_pri;
                    nxt.pend_pri = PRI_LEAST;
                    nxt.pend_src = SRC_NONE;
                end
            end
            OP_MFRR: begin
                nxt.req_pri = mfrr_val;
                if (ipi_takes(mfrr_val, cur.run_pri, cur.pend_pri)) begin
                    rej_v        = reportable(cur.pend_src);
                    rej_src      = rej_v ? cur.pend_src : SRC_NONE;
                    nxt.pend_src = SRC_IPI;
                    nxt.pend_pri = mfrr_val;
                end
                if (mfrr_val > cur.req_pri) begin
                    resend_p = cur.lost;
                    nxt.lost = 1'b0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import ipu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dlv_req,
    input  logic [SRC_W-1:0]  dlv_src,
    input  logic [PRI_W-1:0]  dlv_prio,
    output logic              dlv_done,
    output logic              dlv_ok,
    input  logic              acc_req,
    output logic              acc_done,
    output logic [WORD_W-1:0] acc_word,
    input  logic              mfrr_req,
    input  logic [PRI_W-1:0]  mfrr_val,
    input  logic              cppr_req,
    input  logic [PRI_W-1:0]  cppr_val,
    input  logic              eoi_req,
    input  logic [WORD_W-1:0] eoi_word,
    output logic              irq_out,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              resend_pulse,
    output logic              seoi_valid,
    output logic [SRC_W-1:0]  seoi_src
);

    op_e     op;
    pstate_t st_q, st_d;
    pevent_t ev_q, ev_d;

    pstate_t           dl_nxt;
    logic              dl_ok, dl_rej_v;
    src_t              dl_rej_src;

    pstate_t           ct_nxt;
    logic              ct_acc, ct_rej_v, ct_resend, ct_seoi_v;
    logic [WORD_W-1:0] ct_word;
    src_t              ct_rej_src, ct_seoi_src;

    ipu_arbiter u_arb (
        .eoi_req  (eoi_req),
        .cppr_req (cppr_req),
        .acc_req  (acc_req),
        .mfrr_req (mfrr_req),
        .dlv_req  (dlv_req),
        .op       (op)
    );

    ipu_delivery u_dlv (
        .cur     (st_q),
        .src     (dlv_src),
        .pri     (dlv_prio),
        .ok      (dl_ok),
        .nxt     (dl_nxt),
        .rej_v   (dl_rej_v),
        .rej_src (dl_rej_src)
    );

    ipu_control u_ctl (
        .op       (op),
        .cur      (st_q),
        .mfrr_val (mfrr_val),
        .cppr_val (cppr_val),
        .eoi_word (eoi_word),
        .nxt      (ct_nxt),
        .acc_done (ct_acc),
        .acc_word (ct_word),
        .rej_v    (ct_rej_v),
        .rej_src  (ct_rej_src),
        .resend_p (ct_resend),
        .seoi_v   (ct_seoi_v),
        .seoi_src (ct_seoi_src)
    );

    always_comb begin
        ev_d = '0;
        st_d = st_q;
        case (op)
            OP_NONE: ;
            OP_DELIVER: begin
                st_d        = dl_nxt;
                ev_d.dlv_done = 1'b1;
                ev_d.dlv_ok   = dl_ok;
                ev_d.rej_v    = dl_rej_v;
                ev_d.rej_src  = dl_rej_src;
            end
            default: begin
                st_d          = ct_nxt;
                ev_d.acc_done = ct_acc;
                ev_d.acc_word = ct_word;
                ev_d.rej_v    = ct_rej_v;
                ev_d.rej_src  = ct_rej_src;
                ev_d.resend_p = ct_resend;
                ev_d.seoi_v   = ct_seoi_v;
                ev_d.seoi_src = ct_seoi_src;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RESET_STATE;
            ev_q <= '0;
        end else begin
            st_q <= st_d;
            ev_q <= ev_d;
        end
    end

    assign irq_out      = line_level(st_q);
    assign dlv_done     = ev_q.dlv_done;
    assign dlv_ok       = ev_q.dlv_ok;
    assign acc_done     = ev_q.acc_done;
    assign acc_word     = ev_q.acc_word;
    assign rej_valid    = ev_q.rej_v;
    assign rej_src      = ev_q.rej_src;
    assign resend_pulse = ev_q.resend_p;
    assign seoi_valid   = ev_q.seoi_v;
    assign seoi_src     = ev_q.seoi_src;

endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk
    import ipu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dlv_req,
    input logic [PRI_W-1:0]  dlv_prio,
    input logic              dlv_done,
    input logic              dlv_ok,
    input logic              acc_req,
    input logic              acc_done,
    input logic [WORD_W-1:0] acc_word,
    input logic              mfrr_req,
    input logic              cppr_req,
    input logic [PRI_W-1:0]  cppr_val,
    input logic              eoi_req,
    input logic [WORD_W-1:0] eoi_word,
    input logic              irq_out,
    input logic              rej_valid,
    input logic [SRC_W-1:0]  rej_src,
    input logic              resend_pulse,
    input logic              seoi_valid,
    input logic [SRC_W-1:0]  seoi_src,
    input pstate_t           st
);

    assert_dlv_cause_R3: assert property (@(posedge clk) disable iff (rst)
        dlv_done |-> $past(dlv_req));

    assert_dlv_refuse_R3: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && !eoi_req && !cppr_req && !acc_req && !mfrr_req && (dlv_prio >= st.run_pri))
        |=> (dlv_done && !dlv_ok));

    assert_rej_real_R4: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> ((rej_src != SRC_NONE) && (rej_src != SRC_IPI)));

    assert_refuse_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (dlv_done && !dlv_ok) |-> st.lost);

    assert_acc_pending_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !eoi_req && !cppr_req && irq_out)
        |=> (acc_done && (acc_word[SRC_W-1:0] != SRC_NONE)));

    assert_resend_flag_R8: assert property (@(posedge clk) disable iff (rst)
        resend_pulse |-> ($past(st.lost) && !st.lost));

    assert_raise_reject_R10: assert property (@(posedge clk) disable iff (rst)
        (cppr_req && !eoi_req && (cppr_val < st.run_pri) && (cppr_val <= st.pend_pri)
         && (st.pend_src != SRC_NONE) && (st.pend_src != SRC_IPI))
        |=> (rej_valid && (rej_src == $past(st.pend_src))));

    assert_eoi_fwd_R11: assert property (@(posedge clk) disable iff (rst)
        (eoi_req && (eoi_word[SRC_W-1:0] != SRC_IPI))
        |=> (seoi_valid && (seoi_src == $past(eoi_word[SRC_W-1:0]))));

    assert_one_op_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dlv_done, acc_done, seoi_valid}));

    assert_eoi_rank_R12: assert property (@(posedge clk) disable iff (rst)
        eoi_req |=> (!dlv_done && !acc_done));

endmodule

bind irq_presenter irq_presenter_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .dlv_req      (dlv_req),
    .dlv_prio     (dlv_prio),
    .dlv_done     (dlv_done),
    .dlv_ok       (dlv_ok),
    .acc_req      (acc_req),
    .acc_done     (acc_done),
    .acc_word     (acc_word),
    .mfrr_req     (mfrr_req),
    .cppr_req     (cppr_req),
    .cppr_val     (cppr_val),
    .eoi_req      (eoi_req),
    .eoi_word     (eoi_word),
    .irq_out      (irq_out),
    .rej_valid    (rej_valid),
    .rej_src      (rej_src),
    .resend_pulse (resend_pulse),
    .seoi_valid   (seoi_valid),
    .seoi_src     (seoi_src),
    .st           (st_q)
);

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
    import ipu_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              dlv_req = 1'b0, acc_req = 1'b0, mfrr_req = 1'b0, cppr_req = 1'b0, eoi_req = 1'b0;
    logic [SRC_W-1:0]  dlv_src = '0;
    logic [PRI_W-1:0]  dlv_prio = '0, mfrr_val = '0, cppr_val = '0;
    logic [WORD_W-1:0] eoi_word = '0;
    logic              dlv_done, dlv_ok, acc_done, irq_out, rej_valid, resend_pulse, seoi_valid;
    logic [WORD_W-1:0] acc_word;
    logic [SRC_W-1:0]  rej_src, seoi_src;

    irq_presenter uut (
        .clk(clk), .rst(rst),
        .dlv_req(dlv_req), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
        .dlv_done(dlv_done), .dlv_ok(dlv_ok),
        .acc_req(acc_req), .acc_done(acc_done), .acc_word(acc_word),
        .mfrr_req(mfrr_req), .mfrr_val(mfrr_val),
        .cppr_req(cppr_req), .cppr_val(cppr_val),
        .eoi_req(eoi_req), .eoi_word(eoi_word),
        .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
        .resend_pulse(resend_pulse), .seoi_valid(seoi_valid), .seoi_src(seoi_src)
    );

    typedef struct packed {
        int                due;
        logic              irq;
        logic              dd;
        logic              dok;
        logic              ad;
        logic [WORD_W-1:0] aw;
        logic              rv;
        logic [SRC_W-1:0]  rs;
        logic              rp;
        logic              sv;
        logic [SRC_W-1:0]  ss;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    ended = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // reference model of the requirements
    logic [7:0]  m_run = 8'h00, m_req = 8'hFF, m_ppri = 8'hFF;
    logic [23:0] m_src = 24'h0;
    logic        m_lost = 1'b0;
    exp_t        xe;

    task automatic m_reject();
        if (m_src != 24'd0 && m_src != 24'd2) begin
            xe.rv = 1'b1;
            xe.rs = m_src;
        end
    endtask

    task automatic m_lower(input logic [7:0] c);
        m_run = c;
        if (m_req < c && m_req <= m_ppri) begin
            m_src  = 24'd2;
            m_ppri = m_req;
        end
        xe.rp  = m_lost;
        m_lost = 1'b0;
    endtask

    task automatic step(input logic e, input logic [31:0] ev,
                        input logic c, input logic [7:0] cv,
                        input logic a,
                        input logic m, input logic [7:0] mv,
                        input logic d, input logic [23:0] ds, input logic [7:0] dp,
                        input string tag);
        @(negedge clk);
        eoi_req = e;  eoi_word = ev;
        cppr_req = c; cppr_val = cv;
        acc_req = a;
        mfrr_req = m; mfrr_val = mv;
        dlv_req = d;  dlv_src = ds; dlv_prio = dp;
        xe = '0;
        xe.due = cyc + 1;
        if (e) begin                                   // R12 rank 1
            m_lower(ev[31:24]);                        // R11
            if (ev[23:0] != 24'd2) begin
                xe.sv = 1'b1;
                xe.ss = ev[23:0];
            end
        end else if (c) begin                          // R12 rank 2
            if (cv > m_run) m_lower(cv);               // R9
            else if (cv < m_run) begin                 // R10
                m_run = cv;
                if (cv <= m_ppri) begin
                    m_reject();
                    m_src  = 24'd0;
                    m_ppri = 8'hFF;
                end
            end
        end else if (a) begin                          // R6
            xe.ad = 1'b1;
            xe.aw = {m_run, m_src};
            if (m_src != 24'd0) begin
                m_run  = m_ppri;
                m_ppri = 8'hFF;
                m_src  = 24'd0;
            end
        end else if (m) begin                          // R7, R8
            if (mv < m_run && mv <= m_ppri) begin
                m_reject();
                m_src  = 24'd2;
                m_ppri = mv;
            end
            if (mv > m_req) begin
                xe.rp  = m_lost;
                m_lost = 1'b0;
            end
            m_req = mv;
        end else if (d) begin                          // R3, R4, R5
            xe.dd = 1'b1;
            if (m_run > dp && m_req > dp && m_ppri > dp) begin
                xe.dok = 1'b1;
                m_reject();
                m_src  = ds;
                m_ppri = dp;
            end else begin
                m_lost = 1'b1;
            end
        end
        xe.irq = (m_src != 24'd0) && (m_ppri < m_run);  // R2
        q.push_back(xe);
        tq.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic dlv(input logic [23:0] s, input logic [7:0] p, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 1, s, p, tag);
    endtask
    task automatic acc(input string tag);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic wr_mfrr(input logic [7:0] v, input string tag);
        step(0, 0, 0, 0, 0, 1, v, 0, 0, 0, tag);
    endtask
    task automatic wr_cppr(input logic [7:0] v, input string tag);
        step(0, 0, 1, v, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic eoi(input logic [31:0] w, input string tag);
        step(1, w, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: pops the item due this cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t  ex, ac;
                string t;
                ex = q.pop_front();
                t  = tq.pop_front();
                ac = '{due: ex.due, irq: irq_out, dd: dlv_done, dok: dlv_ok, ad: acc_done,
                       aw: acc_word, rv: rej_valid, rs: rej_src, rp: resend_pulse,
                       sv: seoi_valid, ss: seoi_src};
                n_cmp++;
                if (ac !== ex) begin
                    n_bad++;
                    $display("FAIL %s: actual irq=%b done=%b ok=%b acc=%b word=%h rej=%b/%h resend=%b seoi=%b/%h | expected irq=%b done=%b ok=%b acc=%b word=%h rej=%b/%h resend=%b seoi=%b/%h",
                             t, ac.irq, ac.dd, ac.dok, ac.ad, ac.aw, ac.rv, ac.rs, ac.rp, ac.sv, ac.ss,
                             ex.irq, ex.dd, ex.dok, ex.ad, ex.aw, ex.rv, ex.rs, ex.rp, ex.sv, ex.ss);
                end
            end
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R1 reset outputs");
        acc("R1 R6 reset acknowledge word");
        dlv(24'h000100, 8'h05, "R3 R5 refused at running priority 0");
        wr_cppr(8'hFF, "R9 R5 lowering consumes flag");
        dlv(24'h000100, 8'h05, "R3 R2 first accept");
        dlv(24'h000200, 8'h03, "R4 displace real source");
        dlv(24'h000300, 8'h03, "R3 equal priority refused");
        wr_mfrr(8'h01, "R7 IPI displaces pending source");
        dlv(24'h000400, 8'h00, "R4 IPI displaced without report");
        acc("R6 acknowledge moves priority");
        wr_mfrr(8'h80, "R8 raise request priority pulses resend");
        eoi(32'hFF000400, "R11 R9 end of service with IPI pickup");
        acc("R6 acknowledge IPI");
        eoi(32'hFF000002, "R11 IPI number not forwarded");
        wr_cppr(8'h80, "R10 raise drops IPI without report");
        wr_cppr(8'h80, "R10 equal write no effect");
        dlv(24'h000500, 8'h10, "R3 accept below request priority");
        wr_cppr(8'h20, "R10 raise above pending keeps it");
        wr_cppr(8'h10, "R10 raise to pending rejects");
        dlv(24'h000550, 8'h08, "R3 accept for boundary");
        eoi(32'h08000550, "R2 R11 equal priorities give no line");
        step(1, 32'hF0000600, 1, 8'h01, 1, 1, 8'h00, 1, 24'h000700, 8'h00,
             "R12 all five requests end of service wins");
        step(0, 0, 0, 0, 1, 1, 8'h00, 1, 24'h000700, 8'h00,
             "R12 acknowledge beats request and delivery");
        step(0, 0, 0, 0, 0, 1, 8'hFF, 1, 24'h000700, 8'h00,
             "R12 request write beats delivery");
        acc("R12 losers left state untouched");
        idle("R5 idle tail");
        while (q.size() > 0) @(negedge clk);
        ended = 1'b1;
        report();
    end

endmodule